// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block takes a 64-bit interrupt command word and works out which of a set of local agents the interrupt is for. It returns a per-agent delivery mask. It sits between the command source and the agents, and each agent presents its own identity to it. That identity is a physical ID, a logical destination byte and a destination-format model. The block does not post vectors. It only resolves the target set.

There are two ways to address agents. In physical mode the command names one ID, or uses the broadcast value. In logical mode each agent matches according to its own format model, either flat or cluster. A two-bit shorthand field can override the address and select the sender, all agents, or all agents but the sender. Two delivery modes reshape the result. Lowest-priority mode narrows the set to one agent. The INIT level-deassert form delivers nothing; instead it reports which agents must reload their arbitration ID from their physical ID.

A result is registered. It appears one clock after the command is accepted, together with a single-cycle valid strobe.

Top module: `intr_dest_resolver`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` is 0 and both `deliver_mask` and `arb_reload_mask` are all zeros.
- R2: `res_valid` is 1 in exactly the cycle after each cycle with `cmd_valid` high, and 0 otherwise. Whenever `res_valid` is 0, both masks are zero.
- R3: The shorthand field is `cmd_word[19:18]`. Value 0 uses the address fields. Value 1 selects only the agent at index `sender_idx`. Value 2 selects every agent. Value 3 selects every agent except `sender_idx`.
- R4: Physical addressing applies when `cmd_word[11]` = 0. The destination is `cmd_word[63:56]`. The value 0xFF selects all agents. Any other value selects the lowest-indexed agent whose ID equals the destination, or no agent if none matches.
- R5: Logical addressing applies when `cmd_word[11]` = 1. An agent with format model 0xF matches when the bitwise AND of the destination and its logical byte is nonzero.
- R6: In logical addressing, an agent with format model 0x0 matches when the upper nibbles of the destination and its logical byte are equal and the AND of their lower nibbles is nonzero. Any other format value never matches.
- R7: The delivery mode is `cmd_word[10:8]`. Mode 1 (lowest priority) reduces the selection to only its lowest-indexed agent, and to no agent if the selection is empty.
- R8: Mode 5 with `cmd_word[14]` = 0 and `cmd_word[15]` = 1 gives a zero `deliver_mask` and puts the selection on `arb_reload_mask`. In every other case `arb_reload_mask` is zero.
- R9: For every other delivery-mode, level and trigger combination, `deliver_mask` equals the selection, and the vector field `cmd_word[7:0]` has no effect on either mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_word | input | 64 | Interrupt command word |
| sender_idx | input | $clog2(N_AGENTS) | Index of the sending agent |
| agent_id | input | N_AGENTS*8 | Physical IDs, agent i in bits [8i+7:8i] |
| agent_ldest | input | N_AGENTS*8 | Logical destination bytes, agent i in bits [8i+7:8i] |
| agent_fmt | input | N_AGENTS*4 | Format models, agent i in bits [4i+3:4i] |
| res_valid | output | 1 | One-cycle result strobe |
| deliver_mask | output | N_AGENTS | Agents that receive the interrupt |
| arb_reload_mask | output | N_AGENTS | Agents that reload their arbitration ID |

## Verification
The assertions assume that `sender_idx` is below N_AGENTS. They also assume that the agent identity inputs and the command are stable for the cycle in which they are sampled. The result-shape properties compare against the command as it was one cycle earlier.

The stimulus keeps to these assumptions in three ways:
- It uses a four-agent configuration with sender indices 0 to 3 only.
- It changes inputs only on the falling edge.
- It sweeps every destination byte, shorthand, delivery mode and level/trigger pair across three agent configurations, which mix duplicate IDs, flat, cluster and unused format values.

// File: rtl/intr_dest_resolver.sv
module intr_dest_resolver #(
  parameter int N_AGENTS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  input  logic [63:0]                   cmd_word,
  input  logic [$clog2(N_AGENTS)-1:0]   sender_idx,
  input  logic [N_AGENTS*8-1:0]         agent_id,
  input  logic [N_AGENTS*8-1:0]         agent_ldest,
  input  logic [N_AGENTS*4-1:0]         agent_fmt,
  output logic                          res_valid,
  output logic [N_AGENTS-1:0]           deliver_mask,
  output logic [N_AGENTS-1:0]           arb_reload_mask
);
  localparam int DW = 8;
  localparam int FW = 4;
  localparam logic [N_AGENTS-1:0] ALL = '1;
  localparam logic [N_AGENTS-1:0] ONE = 1;
  localparam logic [FW-1:0] FMT_FLAT    = 4'hF;
  localparam logic [FW-1:0] FMT_CLUSTER = 4'h0;

  wire [DW-1:0] dest      = cmd_word[63:56];
  wire [1:0]    shorthand = cmd_word[19:18];
  wire          logical   = cmd_word[11];
  wire [2:0]    dmode     = cmd_word[10:8];
  wire          init_deassert = (dmode == 3'd5) && !cmd_word[14] && cmd_word[15];

  logic [N_AGENTS-1:0] phys_hit, log_hit;

  genvar i;
  generate
    for (i = 0; i < N_AGENTS; i++) begin : g_agent
      wire [DW-1:0] id_i  = agent_id[i*DW +: DW];
      wire [DW-1:0] ld_i  = agent_ldest[i*DW +: DW];
      wire [FW-1:0] fmt_i = agent_fmt[i*FW +: FW];
      wire flat_m  = |(dest & ld_i);
      wire clust_m = (dest[7:4] == ld_i[7:4]) && |(dest[3:0] & ld_i[3:0]);
      assign phys_hit[i] = (id_i == dest);
      assign log_hit[i]  = (fmt_i == FMT_FLAT)    ? flat_m :
                           (fmt_i == FMT_CLUSTER) ? clust_m : 1'b0;
    end
  endgenerate

  wire [N_AGENTS-1:0] phys_first = phys_hit & (~phys_hit + ONE);
  wire [N_AGENTS-1:0] addr_sel   = logical ? log_hit :
                                   (dest == 8'hFF) ? ALL : phys_first;
  wire [N_AGENTS-1:0] self_bit   = ONE << sender_idx;

  logic [N_AGENTS-1:0] sel;
  always_comb begin
    case (shorthand)
      2'd0:    sel = addr_sel;
      2'd1:    sel = self_bit;
      2'd2:    sel = ALL;
      default: sel = ALL & ~self_bit;
    endcase
  end

  wire [N_AGENTS-1:0] lowest = sel & (~sel + ONE);
  wire [N_AGENTS-1:0] del_d  = init_deassert ? '0 :
                               (dmode == 3'd1) ? lowest : sel;
  wire [N_AGENTS-1:0] arb_d  = init_deassert ? sel : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid       <= 1'b0;
      deliver_mask    <= '0;
      arb_reload_mask <= '0;
    end else begin
      res_valid       <= cmd_valid;
      deliver_mask    <= cmd_valid ? del_d : '0;
      arb_reload_mask <= cmd_valid ? arb_d : '0;
    end
  end
endmodule

// File: rtl/intr_dest_resolver_sva.sv
module intr_dest_resolver_sva #(
  parameter int N_AGENTS = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cmd_valid,
  input logic [63:0]                 cmd_word,
  input logic [$clog2(N_AGENTS)-1:0] sender_idx,
  input logic                        res_valid,
  input logic [N_AGENTS-1:0]         deliver_mask,
  input logic [N_AGENTS-1:0]         arb_reload_mask
);
  localparam logic [N_AGENTS-1:0] ONE = 1;

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> res_valid);

  p_valid_needs_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(cmd_valid));

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (deliver_mask == '0 && arb_reload_mask == '0));

  p_self_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(cmd_word[19:18]) == 2'd1)
      |-> ((deliver_mask | arb_reload_mask) == (ONE << $past(sender_idx))));

  p_skip_sender_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(cmd_word[19:18]) == 2'd3)
      |-> (((deliver_mask | arb_reload_mask) & (ONE << $past(sender_idx))) == '0));

  p_lowpri_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(cmd_word[10:8]) == 3'd1) |-> $onehot0(deliver_mask));

  p_init_nodeliver_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(cmd_word[10:8]) == 3'd5 && !$past(cmd_word[14]) && $past(cmd_word[15]))
      |-> (deliver_mask == '0));

  p_reload_only_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_reload_mask != '0)
      |-> ($past(cmd_word[10:8]) == 3'd5 && !$past(cmd_word[14]) && $past(cmd_word[15])));
endmodule

bind intr_dest_resolver intr_dest_resolver_sva #(.N_AGENTS(N_AGENTS)) u_sva (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .sender_idx(sender_idx), .res_valid(res_valid),
  .deliver_mask(deliver_mask), .arb_reload_mask(arb_reload_mask)
);

// File: tb/tb_intr_dest_resolver.sv
`timescale 1ns/1ps
module tb_intr_dest_resolver;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [63:0] cmd_word = '0;
  logic [1:0] sender_idx = '0;
  logic [N*8-1:0] agent_id, agent_ldest;
  logic [N*4-1:0] agent_fmt;
  logic res_valid;
  logic [N-1:0] deliver_mask, arb_reload_mask;

  logic [7:0] ids [N];
  logic [7:0] lds [N];
  logic [3:0] fmts [N];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      agent_id[k*8 +: 8]    = ids[k];
      agent_ldest[k*8 +: 8] = lds[k];
      agent_fmt[k*4 +: 4]   = fmts[k];
    end
  end

  intr_dest_resolver #(.N_AGENTS(N)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .sender_idx(sender_idx), .agent_id(agent_id), .agent_ldest(agent_ldest),
    .agent_fmt(agent_fmt), .res_valid(res_valid), .deliver_mask(deliver_mask),
    .arb_reload_mask(arb_reload_mask)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int c);
    case (c)
      0: begin
        ids  = '{8'h00, 8'h01, 8'h02, 8'h03};
        lds  = '{8'h01, 8'h02, 8'h04, 8'h08};
        fmts = '{4'hF, 4'hF, 4'hF, 4'hF};
      end
      1: begin
        ids  = '{8'h05, 8'h09, 8'h05, 8'hFF};
        lds  = '{8'h13, 8'h21, 8'h12, 8'h2C};
        fmts = '{4'h0, 4'h0, 4'h0, 4'h0};
      end
      default: begin
        ids  = '{8'h07, 8'h03, 8'h03, 8'h80};
        lds  = '{8'hF0, 8'h31, 8'hFF, 8'h3E};
        fmts = '{4'hF, 4'h0, 4'h3, 4'h0};
      end
    endcase
  endtask

  task automatic model(input int sh, input bit dm, input logic [7:0] dest,
                       input int dmode, input bit lvl, input bit trg, input int snd,
                       output logic [N-1:0] e_del, output logic [N-1:0] e_arb);
    logic [N-1:0] s;
    s = '0;
    if (sh == 0) begin
      if (!dm) begin
        if (dest == 8'hFF) s = '1;
        else for (int k = 0; k < N; k++) if (ids[k] == dest && s == '0) s[k] = 1'b1;
      end else begin
        for (int k = 0; k < N; k++) begin
          if (fmts[k] == 4'hF) s[k] = (dest & lds[k]) != 0;
          else if (fmts[k] == 4'h0)
            s[k] = (dest[7:4] == lds[k][7:4]) && ((dest[3:0] & lds[k][3:0]) != 0);
        end
      end
    end else if (sh == 1) s[snd] = 1'b1;
    else if (sh == 2) s = '1;
    else begin s = '1; s[snd] = 1'b0; end
    e_arb = '0;
    e_del = '0;
    if (dmode == 5 && !lvl && trg) e_arb = s;
    else if (dmode == 1) begin
      for (int k = 0; k < N; k++) if (s[k] && e_del == '0) e_del[k] = 1'b1;
    end else e_del = s;
  endtask

  task automatic run(input string tag, input int sh, input bit dm, input logic [7:0] dest,
                     input int dmode, input bit lvl, input bit trg, input int snd,
                     input logic [7:0] vec);
    logic [N-1:0] e_del, e_arb;
    logic [63:0] w;
    w = '0;
    w[63:56] = dest; w[19:18] = 2'(sh); w[15] = trg; w[14] = lvl;
    w[11] = dm; w[10:8] = 3'(dmode); w[7:0] = vec;
    model(sh, dm, dest, dmode, lvl, trg, snd, e_del, e_arb);
    @(negedge clk);
    cmd_word = w; sender_idx = 2'(snd); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check({tag, " valid"}, 16'(res_valid), 16'd1);
    check({tag, " deliver"}, 16'(deliver_mask), 16'(e_del));
    check({tag, " reload"}, 16'(arb_reload_mask), 16'(e_arb));
    @(negedge clk);
    check("R2 idle", {14'd0, res_valid, |(deliver_mask | arb_reload_mask)}, 16'd0);
  endtask

  function automatic string pick(int c, int sh, bit dm, int dmode, bit lvl, bit trg);
    if (dmode == 5 && !lvl && trg) return "R8";
    if (dmode == 1) return "R7";
    if (sh != 0) return "R3";
    if (!dm) return "R4";
    if (c == 0) return "R5";
    return "R6";
  endfunction

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    set_cfg(0);
    repeat (3) @(negedge clk);
    check("R1 reset", {14'd0, res_valid, |(deliver_mask | arb_reload_mask)}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {14'd0, res_valid, |(deliver_mask | arb_reload_mask)}, 16'd0);

    for (int c = 0; c < 3; c++) begin
      set_cfg(c);
      for (int dm = 0; dm < 2; dm++)
        for (int d = 0; d < 256; d++)
          for (int md = 0; md < 2; md++)
            run(pick(c, 0, dm[0], md, 0, 0), 0, dm[0], 8'(d), md, 0, 0, 1, 8'h00);
      for (int sh = 1; sh < 4; sh++)
        for (int s = 0; s < N; s++)
          for (int md = 0; md < 8; md++)
            for (int lt = 0; lt < 4; lt++)
              run(pick(c, sh, 0, md, lt[1], lt[0]), sh, 0, 8'h55, md, lt[1], lt[0], s, 8'h20);
      for (int dm = 0; dm < 2; dm++)
        for (int di = 0; di < 4; di++)
          for (int md = 0; md < 8; md++)
            for (int lt = 0; lt < 4; lt++) begin
              logic [7:0] dv;
              dv = (di == 0) ? 8'h03 : (di == 1) ? 8'h13 : (di == 2) ? 8'hFF : 8'h21;
              run(pick(c, 0, dm[0], md, lt[1], lt[0]), 0, dm[0], dv, md, lt[1], lt[0], 2, 8'h41);
            end
    end

    set_cfg(1);
    for (int v = 0; v < 256; v++) run("R9 vector", 0, 1, 8'h13, 0, 0, 0, 0, 8'(v));

    // R2: back-to-back commands give back-to-back strobes
    @(negedge clk);
    cmd_word = '0; cmd_word[19:18] = 2'd2; cmd_valid = 1'b1;
    @(negedge clk);
    check("R2 first strobe", 16'(res_valid), 16'd1);
    cmd_word[19:18] = 2'd1; sender_idx = 2'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 second strobe", 16'(res_valid), 16'd1);
    check("R3 second result", 16'(deliver_mask), 16'h0008);
    @(negedge clk);
    check("R2 after pair", 16'(res_valid), 16'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule